// File: doc/BRIEF.md
# Attribute-Driven Data Cache Controller

This block sits between a load/store unit and a memory port. It decides, for each request, whether to look the request up in a small direct-mapped write-back cache, whether a miss installs a line, or whether the request skips the cache entirely. The decision depends only on the outer and inner memory attribute codes that travel with the request. Accesses to peripheral-type memory and to uncached or write-through memory never touch the array. Write-back memory is looked up. Write-back memory with an allocate hint installs missing lines. Write-back memory with the no-allocate hint only uses lines that are already resident.

The controller takes one request at a time. Each request finishes with a single response pulse, for loads and stores alike. The memory port carries three kinds of transaction: a single read, a line read and a byte-masked line write. Each is held until the memory acknowledges it. Every memory transaction carries the outer attribute of the request that caused it, so downstream logic can apply its own allocation policy.

Top module: `dcache_attr_ctrl`

## Requirements
- R1: Attribute codes are 4 bits: 0 to 3 peripheral (four ordering variants), 4 uncached, 5 write-through, 8 write-back no-allocate, 9 write-back read-allocate, 10 write-back write-allocate, 11 write-back read-write-allocate, and any other code is treated as uncached. A request is cacheable only when both the outer code and the inner code are in 8 to 11. Otherwise, if neither side is peripheral, the request is uncached.
- R2: A request with a peripheral code on either side never consults or changes the cache. A load issues a single read (mem_kind 0, mem_addr equal to the request address) and returns the memory word from its lane of mem_rdata. A store issues a masked write.
- R3: With an outer write-back code, inner codes 9, 10 and 11 all behave as read-write-allocate.
- R4: An allocating load that hits returns the cached word with resp_valid two cycles after acceptance and causes no memory transaction.
- R5: A store that hits merges its enabled bytes into the line and marks the line dirty, without writing memory.
- R6: An allocating miss reads the whole aligned line (mem_kind 1, line-aligned mem_addr), installs it clean, and then completes from the cache. A store also merges its bytes and leaves the line dirty.
- R7: If an allocating miss would replace a valid dirty line, the victim is first written back to its own address as a full line (mem_kind 2, all mem_be bits set), and only then is the fill issued.
- R8: A no-allocate access (inner code 8) that hits reads or updates the line in place, exactly as R4 and R5 describe.
- R9: A no-allocate load miss issues a single read, returns the memory word and installs nothing.
- R10: A no-allocate store miss issues a masked write (mem_kind 2, line-aligned address, the request word replicated on every lane, mem_be set only for the enabled bytes of the addressed word: bit 4*w+b for word w, byte b). It installs nothing.
- R11: An uncached load issues a line read and returns only the addressed word. An uncached store issues a masked write. Neither caches anything.
- R12: req_ready is high only while idle. It falls after an accepted request and stays low until the response pulse has been given.
- R13: mem_attr carries the outer code of the current request, unchanged, for every memory transaction. mem_req and the transaction fields stay stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| req_outer | input | 4 | Outer attribute code |
| req_inner | input | 4 | Inner attribute code |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory transaction request |
| mem_ack | input | 1 | Memory completion, with read data |
| mem_kind | output | 2 | 0 single read, 1 line read, 2 masked write |
| mem_addr | output | ADDR_W | Transaction address |
| mem_wdata | output | DATA_W*LINE_WORDS | Write data, one lane per word |
| mem_be | output | DATA_W*LINE_WORDS/8 | Write byte mask |
| mem_attr | output | 4 | Forwarded outer attribute |
| mem_rdata | input | DATA_W*LINE_WORDS | Read data, one lane per word |

## Verification
A load that hits produces resp_valid exactly two cycles after the accepting edge: one cycle to decide and one to respond. The bench counts falling edges from acceptance and requires that count on every hit. Any request that uses memory responds one cycle after the edge that carries mem_ack, plus the time of a write-back and a fill where a miss needs them. For those requests the bench waits for the response pulse, then reads its memory model's transaction log and contents. Whether a line was installed is never inferred from latency alone: it is shown by a later access that either generates memory traffic or does not.

// File: rtl/dca_pkg.sv
package dca_pkg;
  localparam int ATTR_W = 4;

  typedef enum logic [1:0] {
    CLS_DEVICE   = 2'd0,
    CLS_UNCACHED = 2'd1,
    CLS_WB_NOALC = 2'd2,
    CLS_WB_ALLOC = 2'd3
  } mem_class_e;

  typedef enum logic [1:0] {
    MK_SINGLE = 2'd0,
    MK_LINE   = 2'd1,
    MK_WRITE  = 2'd2
  } mem_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_EVICT, S_FILL, S_BYPASS, S_RESP
  } ctrl_state_e;

  localparam logic [ATTR_W-1:0] ATTR_WB_NOALC = 4'd8;

  function automatic logic attr_is_periph(input logic [ATTR_W-1:0] a);
    return a[3:2] == 2'b00;
  endfunction

  function automatic logic attr_is_wb(input logic [ATTR_W-1:0] a);
    return a[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/dca_attr_decode.sv
module dca_attr_decode
  import dca_pkg::*;
(
  input  logic [ATTR_W-1:0] outer_i,
  input  logic [ATTR_W-1:0] inner_i,
  output mem_class_e        cls_o
);
  always_comb begin
    if (attr_is_periph(outer_i) || attr_is_periph(inner_i)) begin
      cls_o = CLS_DEVICE;
    end else if (attr_is_wb(outer_i) && attr_is_wb(inner_i)) begin
      cls_o = (inner_i == ATTR_WB_NOALC) ? CLS_WB_NOALC : CLS_WB_ALLOC;
    end else begin
      cls_o = CLS_UNCACHED;
    end
  end
endmodule

// File: rtl/dca_line_store.sv
module dca_line_store #(
  parameter int SETS   = 8,
  parameter int LINE_W = 128,
  parameter int TAG_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] idx_i,
  output logic                    valid_o,
  output logic                    dirty_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [LINE_W-1:0]       line_o,
  input  logic                    wr_en_i,
  input  logic [TAG_W-1:0]        wr_tag_i,
  input  logic [LINE_W-1:0]       wr_line_i,
  input  logic                    wr_dirty_i
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[idx_i]  <= wr_tag_i;
      data_q[idx_i] <= wr_line_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign line_o  = data_q[idx_i];
endmodule

// File: rtl/dca_lane.sv
module dca_lane #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic [DATA_W*LINE_WORDS-1:0]     line_i,
  input  logic [$clog2(LINE_WORDS)-1:0]    woff_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [DATA_W/8-1:0]              be_i,
  output logic [DATA_W*LINE_WORDS-1:0]     merged_o,
  output logic [DATA_W-1:0]                word_o,
  output logic [DATA_W*LINE_WORDS/8-1:0]   lane_be_o
);
  localparam int BE_W = DATA_W / 8;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      logic sel;
      assign sel = (woff_i == w) && be_i[b];
      assign lane_be_o[w*BE_W+b] = sel;
      assign merged_o[(w*BE_W+b)*8 +: 8] =
        sel ? wdata_i[b*8 +: 8] : line_i[(w*BE_W+b)*8 +: 8];
    end
  end

  assign word_o = line_i[woff_i*DATA_W +: DATA_W];
endmodule

// File: rtl/dcache_attr_ctrl.sv
module dcache_attr_ctrl
  import dca_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_we,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [DATA_W-1:0]              req_wdata,
  input  logic [DATA_W/8-1:0]            req_be,
  input  logic [3:0]                     req_outer,
  input  logic [3:0]                     req_inner,
  output logic                           resp_valid,
  output logic [DATA_W-1:0]              resp_rdata,
  output logic                           mem_req,
  input  logic                           mem_ack,
  output logic [1:0]                     mem_kind,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic [DATA_W*LINE_WORDS-1:0]   mem_wdata,
  output logic [DATA_W*LINE_WORDS/8-1:0] mem_be,
  output logic [3:0]                     mem_attr,
  input  logic [DATA_W*LINE_WORDS-1:0]   mem_rdata
);
  localparam int BE_W    = DATA_W / 8;
  localparam int LINE_W  = DATA_W * LINE_WORDS;
  localparam int BOFF_W  = $clog2(BE_W);
  localparam int WOFF_W  = $clog2(LINE_WORDS);
  localparam int OFF_W   = BOFF_W + WOFF_W;
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  ctrl_state_e state_q, state_d;
  logic              cap_en, rdata_en, wr_en, wr_dirty;
  logic              q_we;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata, rdata_q, rdata_d;
  logic [BE_W-1:0]   q_be;
  logic [3:0]        q_outer;
  mem_class_e        in_cls, q_cls;
  mem_kind_e         kind;
  logic [LINE_W-1:0] wr_line;

  logic [IDX_W-1:0]  q_idx;
  logic [TAG_W-1:0]  q_tag, rd_tag;
  logic [WOFF_W-1:0] q_woff;
  logic              rd_valid, rd_dirty, hit;
  logic [LINE_W-1:0] rd_line, hit_merged;
  logic [DATA_W-1:0] hit_word, mem_word;
  logic [LINE_W/8-1:0] lane_be;
  logic [ADDR_W-1:0] line_addr, victim_addr;

  assign q_idx  = q_addr[OFF_W +: IDX_W];
  assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
  assign q_woff = q_addr[BOFF_W +: WOFF_W];
  assign hit    = rd_valid && (rd_tag == q_tag);
  assign line_addr   = {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign victim_addr = {rd_tag, q_idx, {OFF_W{1'b0}}};
  assign mem_word    = mem_rdata[q_woff*DATA_W +: DATA_W];

  dca_attr_decode u_decode (
    .outer_i (req_outer),
    .inner_i (req_inner),
    .cls_o   (in_cls)
  );

  dca_line_store #(.SETS(SETS), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .idx_i      (q_idx),
    .valid_o    (rd_valid),
    .dirty_o    (rd_dirty),
    .tag_o      (rd_tag),
    .line_o     (rd_line),
    .wr_en_i    (wr_en),
    .wr_tag_i   (q_tag),
    .wr_line_i  (wr_line),
    .wr_dirty_i (wr_dirty)
  );

  dca_lane #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_lane (
    .line_i    (rd_line),
    .woff_i    (q_woff),
    .wdata_i   (q_wdata),
    .be_i      (q_be),
    .merged_o  (hit_merged),
    .word_o    (hit_word),
    .lane_be_o (lane_be)
  );

  // next-state and output decode
  always_comb begin
    state_d   = state_q;
    cap_en    = 1'b0;
    rdata_en  = 1'b0;
    rdata_d   = hit_word;
    wr_en     = 1'b0;
    wr_line   = hit_merged;
    wr_dirty  = 1'b1;
    mem_req   = 1'b0;
    kind      = MK_SINGLE;
    mem_addr  = line_addr;
    mem_wdata = {LINE_WORDS{q_wdata}};
    mem_be    = lane_be;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = S_DECIDE;
        end
      end
      S_DECIDE: begin
        if (q_cls == CLS_DEVICE || q_cls == CLS_UNCACHED) begin
          state_d = S_BYPASS;
        end else if (hit) begin
          wr_en    = q_we;
          rdata_en = !q_we;
          state_d  = S_RESP;
        end else if (q_cls == CLS_WB_NOALC) begin
          state_d = S_BYPASS;
        end else if (rd_valid && rd_dirty) begin
          state_d = S_EVICT;
        end else begin
          state_d = S_FILL;
        end
      end
      S_EVICT: begin
        mem_req   = 1'b1;
        kind      = MK_WRITE;
        mem_addr  = victim_addr;
        mem_wdata = rd_line;
        mem_be    = '1;
        if (mem_ack) state_d = S_FILL;
      end
      S_FILL: begin
        mem_req = 1'b1;
        kind    = MK_LINE;
        if (mem_ack) begin
          wr_en    = 1'b1;
          wr_line  = mem_rdata;
          wr_dirty = 1'b0;
          state_d  = S_DECIDE;
        end
      end
      S_BYPASS: begin
        mem_req = 1'b1;
        if (q_we) begin
          kind = MK_WRITE;
        end else if (q_cls == CLS_UNCACHED) begin
          kind = MK_LINE;
        end else begin
          kind     = MK_SINGLE;
          mem_addr = q_addr;
        end
        if (mem_ack) begin
          rdata_en = !q_we;
          rdata_d  = mem_word;
          state_d  = S_RESP;
        end
      end
      S_RESP: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign mem_kind   = kind;
  assign mem_attr   = q_outer;
  assign req_ready  = (state_q == S_IDLE);
  assign resp_valid = (state_q == S_RESP);
  assign resp_rdata = rdata_q;

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= S_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      q_we    <= req_we;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
      q_be    <= req_be;
      q_outer <= req_outer;
      q_cls   <= in_cls;
    end
    if (rdata_en) rdata_q <= rdata_d;
  end
endmodule

// File: rtl/dca_checker.sv
module dca_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       resp_valid,
  input logic       mem_req,
  input logic       mem_ack,
  input logic [1:0] mem_kind,
  input logic [15:0] mem_addr,
  input logic [3:0] mem_attr
);
  // R12: acceptance closes the request port
  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R12: no response while the port is open, and it reopens afterwards
  a_r12_resp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
  a_r12_reopen_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (req_ready && !resp_valid));

  // R2: a peripheral outer code never produces a line read
  a_r2_periph_no_line: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_attr[3:2] == 2'b00) |-> (mem_kind != 2'd1));

  // R13: transaction held stable until acknowledged
  a_r13_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_kind) && $stable(mem_attr)));

  // R12: no memory traffic while idle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
endmodule

bind dcache_attr_ctrl dca_checker u_dca_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_kind   (mem_kind),
  .mem_addr   (mem_addr),
  .mem_attr   (mem_attr)
);

// File: tb/tb_dcache_attr_ctrl.sv
module tb_dcache_attr_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, req_valid, req_ready, req_we, resp_valid;
  logic [15:0]  req_addr, mem_addr;
  logic [31:0]  req_wdata, resp_rdata;
  logic [3:0]   req_be, req_outer, req_inner, mem_attr;
  logic         mem_req, mem_ack;
  logic [1:0]   mem_kind;
  logic [127:0] mem_wdata, mem_rdata;
  logic [15:0]  mem_be;

  dcache_attr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_outer(req_outer), .req_inner(req_inner), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_kind(mem_kind), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_attr(mem_attr), .mem_rdata(mem_rdata)
  );

  // memory model with transaction log
  logic [31:0] mem [256];
  int   n_single, n_line, n_write, lat_cnt;
  logic [15:0] last_addr, last_wr_addr, last_wr_be;
  logic [3:0]  last_attr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 | i;
      n_single <= 0; n_line <= 0; n_write <= 0; lat_cnt <= 0;
      mem_ack <= 1'b0; mem_rdata <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == 2) begin
        lat_cnt   <= 0;
        mem_ack   <= 1'b1;
        last_addr <= mem_addr;
        last_attr <= mem_attr;
        if (mem_kind == 2'd2) begin
          n_write      <= n_write + 1;
          last_wr_addr <= mem_addr;
          last_wr_be   <= mem_be;
          for (int w = 0; w < 4; w++)
            for (int b = 0; b < 4; b++)
              if (mem_be[w*4+b])
                mem[{mem_addr[9:4], 2'(w)}][8*b +: 8] = mem_wdata[32*w+8*b +: 8];
        end else begin
          if (mem_kind == 2'd1) n_line <= n_line + 1;
          else                  n_single <= n_single + 1;
          for (int w = 0; w < 4; w++)
            mem_rdata[32*w +: 32] <= mem[{mem_addr[9:4], 2'(w)}];
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  int n_chk = 0, n_err = 0;
  int s_single, s_line, s_write;
  bit ready_bad;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic snap();
    s_single = n_single; s_line = n_line; s_write = n_write;
  endtask

  task automatic traffic(input string req, input int ds, input int dl, input int dw);
    chk({req, " single reads"}, 64'(n_single - s_single), 64'(ds));
    chk({req, " line reads"},   64'(n_line - s_line),     64'(dl));
    chk({req, " writes"},       64'(n_write - s_write),   64'(dw));
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input logic [3:0] o, input logic [3:0] i,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    req_be = be; req_outer = o; req_inner = i;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 500) begin
      if (req_ready) ready_bad = 1'b1;
      @(negedge clk);
      lat++;
    end
    if (req_ready) ready_bad = 1'b1;
    rd = resp_rdata;
  endtask

  logic [31:0] rd, exp_w;
  int lat;

  task automatic t_reset();
    chk("R12 reset ready", 64'(req_ready), 64'd1);
    chk("R12 reset resp", 64'(resp_valid), 64'd0);
    chk("R13 reset mem_req", 64'(mem_req), 64'd0);
  endtask

  task automatic t_alloc_read();
    snap();
    access(1'b0, 16'h0104, 0, 4'h0, 4'd11, 4'd11, rd, lat);
    traffic("R6 alloc miss", 0, 1, 0);
    chk("R6 miss data", 64'(rd), 64'(mem[8'h41]));
    chk("R13 fill addr", 64'(last_addr), 64'h0100);
    chk("R13 fill attr", 64'(last_attr), 64'd11);
    snap();
    access(1'b0, 16'h0108, 0, 4'h0, 4'd11, 4'd11, rd, lat);
    traffic("R4 hit", 0, 0, 0);
    chk("R4 hit data", 64'(rd), 64'(mem[8'h42]));
    chk("R4 hit latency", 64'(lat), 64'd2);
  endtask

  task automatic t_store_hit();
    exp_w = merge(mem[8'h41], 32'hAABBCCDD, 4'b0101);
    snap();
    access(1'b1, 16'h0104, 32'hAABBCCDD, 4'b0101, 4'd11, 4'd11, rd, lat);
    traffic("R5 store hit", 0, 0, 0);
    chk("R5 memory untouched", 64'(mem[8'h41]), 64'hC0DE0041);
    access(1'b0, 16'h0104, 0, 4'h0, 4'd11, 4'd11, rd, lat);
    chk("R5 merged readback", 64'(rd), 64'(exp_w));
  endtask

  task automatic t_evict();
    exp_w = merge(32'hC0DE0041, 32'hAABBCCDD, 4'b0101);
    snap();
    access(1'b0, 16'h0184, 0, 4'h0, 4'd11, 4'd11, rd, lat);
    traffic("R7 evict", 0, 1, 1);
    chk("R7 victim addr", 64'(last_wr_addr), 64'h0100);
    chk("R7 victim mask", 64'(last_wr_be), 64'hFFFF);
    chk("R7 victim data", 64'(mem[8'h41]), 64'(exp_w));
    chk("R7 fill after", 64'(last_addr), 64'h0180);
    chk("R7 new data", 64'(rd), 64'(mem[8'h61]));
  endtask

  task automatic t_promote();
    snap();
    access(1'b0, 16'h0214, 0, 4'h0, 4'd11, 4'd9, rd, lat);
    traffic("R3 read-alloc fill", 0, 1, 0);
    access(1'b0, 16'h0214, 0, 4'h0, 4'd11, 4'd11, rd, lat);
    traffic("R3 read-alloc installed", 0, 1, 0);
    chk("R3 data", 64'(rd), 64'(mem[8'h85]));
    snap();
    access(1'b1, 16'h0224, 32'h12345678, 4'hF, 4'd11, 4'd10, rd, lat);
    traffic("R3 write-alloc fill", 0, 1, 0);
    access(1'b0, 16'h0224, 0, 4'h0, 4'd11, 4'd11, rd, lat);
    traffic("R6 store completes in cache", 0, 1, 0);
    chk("R6 store merged", 64'(rd), 64'h12345678);
    chk("R6 memory not written", 64'(mem[8'h89]), 64'hC0DE0089);
  endtask

  task automatic t_na_read_miss();
    snap();
    access(1'b0, 16'h0330, 0, 4'h0, 4'd11, 4'd8, rd, lat);
    traffic("R9 single read", 1, 0, 0);
    chk("R9 addr", 64'(last_addr), 64'h0330);
    chk("R9 data", 64'(rd), 64'(mem[8'hCC]));
    access(1'b0, 16'h0330, 0, 4'h0, 4'd11, 4'd8, rd, lat);
    traffic("R9 not installed", 2, 0, 0);
  endtask

  task automatic t_na_write_miss();
    exp_w = merge(mem[8'hD1], 32'h55667788, 4'b0011);
    snap();
    access(1'b1, 16'h0344, 32'h55667788, 4'b0011, 4'd11, 4'd8, rd, lat);
    traffic("R10 masked write", 0, 0, 1);
    chk("R10 addr", 64'(last_wr_addr), 64'h0340);
    chk("R10 mask", 64'(last_wr_be), 64'h0030);
    chk("R10 memory bytes", 64'(mem[8'hD1]), 64'(exp_w));
    snap();
    access(1'b0, 16'h0344, 0, 4'h0, 4'd11, 4'd8, rd, lat);
    traffic("R10 not installed", 1, 0, 0);
    chk("R10 readback", 64'(rd), 64'(exp_w));
  endtask

  task automatic t_na_hit();
    snap();
    access(1'b0, 16'h0224, 0, 4'h0, 4'd11, 4'd8, rd, lat);
    traffic("R8 read hit", 0, 0, 0);
    chk("R8 read data", 64'(rd), 64'h12345678);
    chk("R8 hit latency", 64'(lat), 64'd2);
    access(1'b1, 16'h0224, 32'h000000EE, 4'b0001, 4'd11, 4'd8, rd, lat);
    access(1'b0, 16'h0224, 0, 4'h0, 4'd11, 4'd11, rd, lat);
    traffic("R8 write hit", 0, 0, 0);
    chk("R8 updated in place", 64'(rd), 64'h123456EE);
  endtask

  task automatic t_device();
    snap();
    access(1'b0, 16'h0224, 0, 4'h0, 4'd0, 4'd0, rd, lat);
    traffic("R2 outer periph", 1, 0, 0);
    chk("R2 bypasses cached line", 64'(rd), 64'hC0DE0089);
    chk("R2 single addr", 64'(last_addr), 64'h0224);
    chk("R13 periph attr", 64'(last_attr), 64'd0);
    access(1'b0, 16'h0224, 0, 4'h0, 4'd11, 4'd2, rd, lat);
    traffic("R2 inner periph", 2, 0, 0);
    chk("R13 outer forwarded", 64'(last_attr), 64'd11);
    exp_w = merge(mem[8'h8A], 32'hDEADBEEF, 4'hF);
    access(1'b1, 16'h0228, 32'hDEADBEEF, 4'hF, 4'd3, 4'd3, rd, lat);
    traffic("R2 periph write", 2, 0, 1);
    chk("R2 write mask", 64'(last_wr_be), 64'h0F00);
    chk("R2 write data", 64'(mem[8'h8A]), 64'(exp_w));
    snap();
    access(1'b0, 16'h0224, 0, 4'h0, 4'd11, 4'd11, rd, lat);
    traffic("R2 cache unchanged", 0, 0, 0);
    chk("R2 cached value kept", 64'(rd), 64'h123456EE);
  endtask

  task automatic t_uncached();
    snap();
    access(1'b0, 16'h0254, 0, 4'h0, 4'd4, 4'd11, rd, lat);
    traffic("R11 line read", 0, 1, 0);
    chk("R11 addr", 64'(last_addr), 64'h0250);
    chk("R11 data", 64'(rd), 64'(mem[8'h95]));
    access(1'b0, 16'h0254, 0, 4'h0, 4'd4, 4'd11, rd, lat);
    traffic("R11 not cached", 0, 2, 0);
    access(1'b0, 16'h0258, 0, 4'h0, 4'd11, 4'd5, rd, lat);
    traffic("R1 inner write-through", 0, 3, 0);
    chk("R1 write-through data", 64'(rd), 64'(mem[8'h96]));
    access(1'b0, 16'h0258, 0, 4'h0, 4'd11, 4'd6, rd, lat);
    traffic("R1 undefined code", 0, 4, 0);
    access(1'b0, 16'h0258, 0, 4'h0, 4'd5, 4'd11, rd, lat);
    traffic("R1 outer write-through", 0, 5, 0);
    exp_w = merge(mem[8'h97], 32'h99000000, 4'b1000);
    access(1'b1, 16'h025C, 32'h99000000, 4'b1000, 4'd5, 4'd5, rd, lat);
    traffic("R11 masked write", 0, 5, 1);
    chk("R11 write mask", 64'(last_wr_be), 64'h8000);
    chk("R11 write data", 64'(mem[8'h97]), 64'(exp_w));
    chk("R13 write attr", 64'(last_attr), 64'd5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R12 watchdog: got no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
    req_wdata = '0; req_be = '0; req_outer = '0; req_inner = '0;
    ready_bad = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_alloc_read();
    t_store_hit();
    t_evict();
    t_promote();
    t_na_read_miss();
    t_na_write_miss();
    t_na_hit();
    t_device();
    t_uncached();
    chk("R12 ready low while busy", 64'(ready_bad), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule